// File: doc/BRIEF.md
# Store-to-Load Forwarding Search Unit

This unit holds a circular queue of pending stores and answers one load query per cycle. The query says whether the load can take its data straight from an older store still in the queue, whether it must wait because an older store covers only part of its bytes, or whether it is free to read memory. Stores go into the queue in two steps. An allocation step reserves a slot and tags it with a sequence number. A write step later fills in the address, the byte count, up to eight data bytes and an uncacheable flag.

A load brings its address, its byte count and its queue position. The queue position is the slot that was next to be allocated when the load was dispatched, so the youngest store older than the load sits one slot below it. The search starts there and steps toward older slots, wrapping from slot 0 to the top slot. It goes no further than the oldest store that has not yet been written back, which an outside pointer gives. The youngest store that overlaps the load decides the result. The result appears on registered outputs one cycle after the query.

Top module: `sqf_unit`

## Requirements
- R1: After reset every slot is unsized (byte count zero) and all result outputs are low, so every load query reports the memory path.
- R2: A query searches only the slots from `wb_ptr` up to `ld_sq_pos - 1`, wrapping modulo the depth. When `ld_sq_pos == wb_ptr` nothing is searched and the result is the memory path.
- R3: Among the searched slots, the one nearest below `ld_sq_pos` that overlaps the load decides the result. The walk wraps from slot 0 to slot DEPTH-1.
- R4: A slot whose byte count is zero is skipped. An allocation sets the slot's byte count to zero.
- R5: A slot marked uncacheable is skipped, whatever its address.
- R6: When load address ≥ store address and load address + load size ≤ store address + store size, the result is a forward. `fwd_data` byte 0 is store data byte (load address AND (store size − 1)), the bytes above follow in order, and bytes at or above the load size read zero. Store sizes are 1, 2, 4 or 8 bytes, naturally aligned.
- R7: Any other overlap of the two byte ranges is a stall. `stall_valid` is set, `stall_seq` carries the sequence number of the deciding store and `fwd_data` is zero.
- R8: When no searched slot overlaps the load, `mem_valid` is set.
- R9: Results appear exactly one cycle after `ld_req`. Exactly one of `fwd_valid`, `stall_valid` and `mem_valid` is high for each query, and all three are low in a cycle that follows no query.
- R10: A write records address, size, data and uncacheable flag in the slot, and a load in any later cycle sees them. An allocation records the sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Reserve a slot |
| alloc_idx | input | IDX_W | Slot to reserve |
| alloc_seq | input | SEQ_W | Sequence number of the reserved store |
| wr_en | input | 1 | Fill a slot with store contents |
| wr_idx | input | IDX_W | Slot to fill |
| wr_addr | input | ADDR_W | Store byte address |
| wr_size | input | SIZE_W | Store byte count |
| wr_data | input | 8*DATA_BYTES | Store data, byte 0 in bits 7:0 |
| wr_uncached | input | 1 | Store is uncacheable |
| wb_ptr | input | IDX_W | Oldest store not yet written back |
| ld_req | input | 1 | Load query this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load byte count, 1 to DATA_BYTES |
| ld_sq_pos | input | IDX_W | Queue position recorded at load dispatch |
| fwd_valid | output | 1 | Data forwarded |
| fwd_data | output | 8*DATA_BYTES | Forwarded bytes, byte 0 in bits 7:0 |
| stall_valid | output | 1 | Partial overlap, load must retry |
| stall_seq | output | SEQ_W | Sequence number of the blocking store |
| mem_valid | output | 1 | Load must read memory |
| hit_idx | output | IDX_W | Deciding slot for a forward or a stall, else zero |

## Verification
A wrong slot contents or a wrong search window shows up at the ports on the next query that touches the slot. The query then reports the wrong one of the three results, or it forwards bytes from the wrong store, one cycle after `ld_req`. A fault in youngest-first priority is visible only when two eligible slots overlap the same load, so the directed cases stack stores on one address and place them on both sides of the wrap point. Skipped slots (unsized or uncacheable) are placed at the same address as a live older store, so that a wrongly taken slot changes the returned bytes.

// File: rtl/sqf_pkg.sv
package sqf_pkg;

    typedef enum logic [1:0] {
        OV_NONE = 2'd0,
        OV_FULL = 2'd1,
        OV_PART = 2'd2
    } overlap_e;

endpackage

// File: rtl/sqf_store_array.sv
module sqf_store_array #(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 16,
    parameter int SEQ_W      = 16,
    parameter int DATA_BYTES = 8,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int SIZE_W    = $clog2(DATA_BYTES + 1),
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_uncached,
    output logic [ADDR_W-1:0] e_addr [DEPTH],
    output logic [SIZE_W-1:0] e_size [DEPTH],
    output logic [DATA_W-1:0] e_data [DEPTH],
    output logic              e_unc  [DEPTH],
    output logic [SEQ_W-1:0]  e_seq  [DEPTH]
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] data;
        logic              unc;
        logic [SEQ_W-1:0]  seq;
    } slot_t;

    slot_t [DEPTH-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (alloc_en) begin
            slot_d[alloc_idx].size = '0;
            slot_d[alloc_idx].seq  = alloc_seq;
        end
        if (wr_en) begin
            slot_d[wr_idx].addr = wr_addr;
            slot_d[wr_idx].size = wr_size;
            slot_d[wr_idx].data = wr_data;
            slot_d[wr_idx].unc  = wr_uncached;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign e_addr[g] = slot_q[g].addr;
        assign e_size[g] = slot_q[g].size;
        assign e_data[g] = slot_q[g].data;
        assign e_unc[g]  = slot_q[g].unc;
        assign e_seq[g]  = slot_q[g].seq;
    end

endmodule

// File: rtl/sqf_overlap_cmp.sv
module sqf_overlap_cmp
    import sqf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 4,
    localparam int EW    = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    output overlap_e          kind
);

    logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;
    logic          covers, touches;

    always_comb begin
        ld_lo   = EW'(ld_addr);
        ld_hi   = ld_lo + EW'(ld_size);
        st_lo   = EW'(st_addr);
        st_hi   = st_lo + EW'(st_size);
        covers  = (ld_lo >= st_lo) && (ld_hi <= st_hi);
        touches = (ld_lo < st_hi) && (ld_hi > st_lo);
        if (covers)       kind = OV_FULL;
        else if (touches) kind = OV_PART;
        else              kind = OV_NONE;
    end

endmodule

// File: rtl/sqf_pick.sv
module sqf_pick
    import sqf_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  overlap_e          kind     [DEPTH],
    input  logic              eligible [DEPTH],
    input  logic [IDX_W-1:0]  ld_sq_pos,
    input  logic [IDX_W-1:0]  wb_ptr,
    output logic              hit,
    output logic              hit_full,
    output logic [IDX_W-1:0]  hit_idx
);

    logic [IDX_W-1:0] span;
    logic [IDX_W-1:0] idx;

    always_comb begin
        span     = ld_sq_pos - wb_ptr;
        hit      = 1'b0;
        hit_full = 1'b0;
        hit_idx  = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = ld_sq_pos - IDX_W'(k + 1);
            if (!hit && (k < int'(span)) && eligible[idx] && (kind[idx] != OV_NONE)) begin
                hit      = 1'b1;
                hit_full = (kind[idx] == OV_FULL);
                hit_idx  = idx;
            end
        end
    end

endmodule

// File: rtl/sqf_unit.sv
module sqf_unit
    import sqf_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 16,
    parameter int SEQ_W      = 16,
    parameter int DATA_BYTES = 8,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int SIZE_W    = $clog2(DATA_BYTES + 1),
    localparam int OFF_W     = $clog2(DATA_BYTES),
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_uncached,
    input  logic [IDX_W-1:0]  wb_ptr,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic [IDX_W-1:0]  ld_sq_pos,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              stall_valid,
    output logic [SEQ_W-1:0]  stall_seq,
    output logic              mem_valid,
    output logic [IDX_W-1:0]  hit_idx
);

    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [SIZE_W-1:0] e_size [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic              e_unc  [DEPTH];
    logic [SEQ_W-1:0]  e_seq  [DEPTH];

    sqf_store_array #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .DATA_BYTES(DATA_BYTES)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_seq(alloc_seq),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_uncached(wr_uncached),
        .e_addr(e_addr), .e_size(e_size), .e_data(e_data), .e_unc(e_unc), .e_seq(e_seq)
    );

    overlap_e kind     [DEPTH];
    logic     eligible [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        sqf_overlap_cmp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) cmp_i (
            .ld_addr(ld_addr), .ld_size(ld_size),
            .st_addr(e_addr[g]), .st_size(e_size[g]),
            .kind(kind[g])
        );
        assign eligible[g] = (e_size[g] != '0) && !e_unc[g];
    end

    logic             sel_hit, sel_full;
    logic [IDX_W-1:0] sel_idx;

    sqf_pick #(.DEPTH(DEPTH)) pick_i (
        .kind(kind), .eligible(eligible),
        .ld_sq_pos(ld_sq_pos), .wb_ptr(wb_ptr),
        .hit(sel_hit), .hit_full(sel_full), .hit_idx(sel_idx)
    );

    typedef struct packed {
        logic              fwd;
        logic [DATA_W-1:0] data;
        logic              stall;
        logic [SEQ_W-1:0]  seq;
        logic              mem;
        logic [IDX_W-1:0]  idx;
    } res_t;

    res_t              res_d, res_q;
    logic [SIZE_W-1:0] size_m1;
    logic [OFF_W-1:0]  byte_off;
    logic [DATA_W-1:0] aligned;

    always_comb begin
        size_m1  = e_size[sel_idx] - SIZE_W'(1);
        byte_off = ld_addr[OFF_W-1:0] & size_m1[OFF_W-1:0];
        aligned  = e_data[sel_idx] >> {byte_off, 3'b000};
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (SIZE_W'(b) >= ld_size) aligned[b*8 +: 8] = 8'h00;
        end

        res_d = '0;
        if (ld_req) begin
            if (!sel_hit) begin
                res_d.mem = 1'b1;
            end else if (sel_full) begin
                res_d.fwd  = 1'b1;
                res_d.data = aligned;
                res_d.idx  = sel_idx;
            end else begin
                res_d.stall = 1'b1;
                res_d.seq   = e_seq[sel_idx];
                res_d.idx   = sel_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign fwd_valid   = res_q.fwd;
    assign fwd_data    = res_q.data;
    assign stall_valid = res_q.stall;
    assign stall_seq   = res_q.seq;
    assign mem_valid   = res_q.mem;
    assign hit_idx     = res_q.idx;

endmodule

// File: rtl/sqf_unit_chk.sv
module sqf_unit_chk #(
    parameter int DEPTH      = 8,
    parameter int SEQ_W      = 16,
    parameter int DATA_BYTES = 8,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_req,
    input logic [IDX_W-1:0]  ld_sq_pos,
    input logic [IDX_W-1:0]  wb_ptr,
    input logic              fwd_valid,
    input logic [DATA_W-1:0] fwd_data,
    input logic              stall_valid,
    input logic              mem_valid,
    input logic [IDX_W-1:0]  hit_idx
);

    // R9: one result per query
    a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> $onehot({fwd_valid, stall_valid, mem_valid}));

    // R9: quiet after a cycle with no query
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req |=> !(fwd_valid || stall_valid || mem_valid));

    // R7: a stall carries no data
    a_r7_stall_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        stall_valid |-> (fwd_data == '0));

    // R2: an empty window goes to memory
    a_r2_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && (ld_sq_pos == wb_ptr)) |=> mem_valid);

    // R3: the deciding slot lies inside the searched window
    a_r3_hit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> (!(fwd_valid || stall_valid) ||
                   (IDX_W'($past(ld_sq_pos) - hit_idx - IDX_W'(1)) <
                    IDX_W'($past(ld_sq_pos) - $past(wb_ptr)))));

endmodule

bind sqf_unit sqf_unit_chk #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .DATA_BYTES(DATA_BYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_sq_pos(ld_sq_pos),
    .wb_ptr(wb_ptr), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .stall_valid(stall_valid), .mem_valid(mem_valid), .hit_idx(hit_idx)
);

// File: tb/sqf_unit_tb.sv
module sqf_unit_tb_top;

    localparam int DEPTH = 8;
    localparam int ADDR_W = 16;
    localparam int SEQ_W = 16;
    localparam int DATA_BYTES = 8;
    localparam int IDX_W = 3;
    localparam int SIZE_W = 4;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_en = 1'b0;
    logic [IDX_W-1:0]  alloc_idx = '0;
    logic [SEQ_W-1:0]  alloc_seq = '0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [SIZE_W-1:0] wr_size = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_uncached = 1'b0;
    logic [IDX_W-1:0]  wb_ptr = '0;
    logic              ld_req = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [SIZE_W-1:0] ld_size = '0;
    logic [IDX_W-1:0]  ld_sq_pos = '0;
    logic              fwd_valid, stall_valid, mem_valid;
    logic [DATA_W-1:0] fwd_data;
    logic [SEQ_W-1:0]  stall_seq;
    logic [IDX_W-1:0]  hit_idx;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sqf_unit #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .DATA_BYTES(DATA_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_seq(alloc_seq),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_uncached(wr_uncached), .wb_ptr(wb_ptr),
        .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size), .ld_sq_pos(ld_sq_pos),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .stall_valid(stall_valid),
        .stall_seq(stall_seq), .mem_valid(mem_valid), .hit_idx(hit_idx)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put_store(int idx, int seq, int addr, int size, logic [63:0] data, bit unc);
        @(negedge clk);
        alloc_en = 1'b1; alloc_idx = IDX_W'(idx); alloc_seq = SEQ_W'(seq);
        @(negedge clk);
        alloc_en = 1'b0;
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_addr = ADDR_W'(addr);
        wr_size = SIZE_W'(size); wr_data = data; wr_uncached = unc;
        @(negedge clk);
        wr_en = 1'b0; wr_uncached = 1'b0;
    endtask

    task automatic realloc(int idx, int seq);
        @(negedge clk);
        alloc_en = 1'b1; alloc_idx = IDX_W'(idx); alloc_seq = SEQ_W'(seq);
        @(negedge clk);
        alloc_en = 1'b0;
    endtask

    // kind: 0 memory, 1 forward, 2 stall
    task automatic load_chk(string req, int pos, int addr, int size, int kind,
                            logic [63:0] exp_data, int exp_seq);
        @(negedge clk);
        ld_req = 1'b1; ld_sq_pos = IDX_W'(pos); ld_addr = ADDR_W'(addr); ld_size = SIZE_W'(size);
        @(negedge clk);
        ld_req = 1'b0;
        chk(req, "flags fwd/stall/mem", {61'd0, fwd_valid, stall_valid, mem_valid},
            (kind == 1) ? 64'd4 : (kind == 2) ? 64'd2 : 64'd1);
        if (kind == 1) chk(req, "fwd_data", fwd_data, exp_data);
        if (kind == 2) begin
            chk(req, "stall_seq", 64'(stall_seq), 64'(exp_seq));
            chk("R7", "fwd_data on stall", fwd_data, 64'd0);
        end
        @(negedge clk);
        chk("R9", "quiet after query", {61'd0, fwd_valid, stall_valid, mem_valid}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R1", "reset flags", {61'd0, fwd_valid, stall_valid, mem_valid}, 64'd0);
        wb_ptr = 3'd0;
        load_chk("R1", 7, 'h100, 4, 0, 64'd0, 0);
    endtask

    task automatic t_forward();
        wb_ptr = 3'd0;
        put_store(0, 10, 'h100, 8, 64'h8877_6655_4433_2211, 1'b0);
        load_chk("R6", 1, 'h104, 2, 1, 64'h6655, 0);
        load_chk("R6", 1, 'h100, 1, 1, 64'h11, 0);
        load_chk("R10", 1, 'h100, 8, 1, 64'h8877_6655_4433_2211, 0);
    endtask

    task automatic t_youngest();
        put_store(1, 11, 'h100, 4, 64'hAABB_CCDD, 1'b0);
        load_chk("R3", 2, 'h100, 4, 1, 64'hAABB_CCDD, 0);
        load_chk("R3", 1, 'h100, 4, 1, 64'h4433_2211, 0);
    endtask

    task automatic t_partial_none();
        load_chk("R7", 2, 'h102, 4, 2, 64'd0, 11);
        load_chk("R8", 2, 'h200, 4, 0, 64'd0, 0);
        load_chk("R8", 2, 'h108, 1, 0, 64'd0, 0);
    endtask

    task automatic t_window();
        wb_ptr = 3'd1;
        load_chk("R2", 2, 'h104, 2, 0, 64'd0, 0);
        wb_ptr = 3'd2;
        load_chk("R2", 2, 'h100, 4, 0, 64'd0, 0);
        wb_ptr = 3'd0;
    endtask

    task automatic t_skip();
        put_store(2, 12, 'h100, 4, 64'h1234_5678, 1'b0);
        load_chk("R10", 3, 'h100, 4, 1, 64'h1234_5678, 0);
        realloc(2, 13);
        load_chk("R4", 3, 'h100, 4, 1, 64'hAABB_CCDD, 0);
        put_store(3, 14, 'h100, 4, 64'hDEAD_BEEF, 1'b1);
        load_chk("R5", 4, 'h100, 4, 1, 64'hAABB_CCDD, 0);
    endtask

    task automatic t_wrap();
        wb_ptr = 3'd6;
        put_store(6, 20, 'h300, 8, 64'h0102_0304_0506_0708, 1'b0);
        put_store(7, 21, 'h400, 1, 64'h5A, 1'b0);
        load_chk("R3", 0, 'h400, 1, 1, 64'h5A, 0);
        load_chk("R3", 0, 'h306, 2, 1, 64'h0102, 0);
        load_chk("R3", 1, 'h100, 1, 1, 64'h11, 0);
        load_chk("R7", 0, 'h2FE, 4, 2, 64'd0, 20);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_youngest();
        t_partial_none();
        t_window();
        t_skip();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule